// File: doc/BRIEF.md
# Atomic Memory Operation Unit

This block is a controller placed in front of a small internal byte-addressed memory. It carries out indivisible read-modify-write operations. It offers three operations:

- fetch-and-add on 1, 2, 4 or 8 bytes;
- conditional exchange on 1, 2, 4 or 8 bytes;
- paired-word conditional exchange. It compares one 8-byte word and, on a match, stores two 8-byte words into the surrounding 16-byte block.

Each request selects little-endian or big-endian placement of its bytes. Each request also carries an acquire/release tag, which comes back unchanged with the response.

A requester presents an operation with a valid/ready handshake. The unit accepts a request only while it is idle. It reads memory, computes and writes back in three separate cycles, and it blocks every other request until the write is done. The response returns the old memory value, zero-extended to 64 bits, and a flag that says whether memory was written. Requests that are malformed are refused with an error response and leave memory untouched.

Top module: `amo_unit`

## Requirements
- R1: A request is refused when any of these holds:
  - its size is not 1, 2, 4 or 8;
  - its address is not a multiple of its size;
  - its opcode is 3;
  - it is a paired exchange (opcode 2) whose size is not 8.

  A refused request gets a response one cycle after acceptance, with rsp_err_o=1, rsp_ok_o=0 and rsp_old_o=0, and memory is unchanged.
- R2: req_ready_o is 1 exactly when the unit is idle. A request is taken on a clock edge where req_valid_i and req_ready_o are both 1.
- R3: A legal request is answered with a single-cycle rsp_valid_o pulse three cycles after acceptance, with rsp_err_o=0. req_ready_o stays 0 until that response has been given, so no other request reaches memory between the read and the write.
- R4: Fetch-and-add (opcode 0) returns the size bytes at the address, zero-extended. It writes back the low size bytes of (old + req_data_i), discarding any carry out of those bytes. Its rsp_ok_o is always 1.
- R5: Conditional exchange (opcode 1) compares only the low size bytes of the old value with req_cmp_i. On equality it writes the low size bytes of req_data_i and sets rsp_ok_o=1. Otherwise it writes nothing and sets rsp_ok_o=0.
- R6: Paired exchange (opcode 2) compares and returns the 8 bytes at the address. On a match it writes req_data_i at (address & ~8) and req_data_hi_i at (address & ~8) + 8, with rsp_ok_o=1. On a mismatch memory is unchanged and rsp_ok_o=0.
- R7: Byte order is set by req_big_i:
  - With req_big_i=0, the byte at address+i holds value bits 8i+7:8i.
  - With req_big_i=1, that byte holds value byte size-1-i.
  - In a paired exchange the reordering applies within each 8-byte word and never swaps the two words.
- R8: rsp_rel_o equals the req_rel_i of the answered request (0 acquire, 1 release), on error responses too.
- R9: After reset req_ready_o=1, rsp_valid_o=0 and every memory byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Unit idle, request may be taken |
| req_op_i | input | 2 | 0 add, 1 exchange, 2 paired exchange, 3 illegal |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 4 | Byte count |
| req_big_i | input | 1 | 1 selects big-endian placement |
| req_cmp_i | input | 64 | Compare value |
| req_data_i | input | 64 | Add operand or first data word |
| req_data_hi_i | input | 64 | Second data word of a paired exchange |
| req_rel_i | input | 1 | Ordering tag, 0 acquire, 1 release |
| rsp_valid_o | output | 1 | Response present for one cycle |
| rsp_ok_o | output | 1 | Memory was written |
| rsp_err_o | output | 1 | Request refused |
| rsp_old_o | output | 64 | Old value, zero-extended |
| rsp_rel_o | output | 1 | Echoed ordering tag |

## Verification
The bench builds the unit with its default ADDR_W of 6, which gives a 64-byte memory. At that size, every byte can be read back through mismatching exchanges after each test step. A paired exchange that addresses the upper word of a 16-byte block then lands within reach, as does a fetch-and-add whose carry leaves the operand bytes. While the unit is busy, the bench keeps a conflicting request on the inputs to show that it is never taken.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int unsigned WORD_BYTES = 8;
  localparam int unsigned SIZE_W     = 4;

  typedef enum logic [1:0] {
    OP_ADD   = 2'd0,
    OP_CAS   = 2'd1,
    OP_CAS16 = 2'd2,
    OP_BAD   = 2'd3
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_CALC,
    ST_WRITE,
    ST_ERR
  } amo_state_e;

  function automatic logic [WORD_BYTES-1:0] size_mask(logic [SIZE_W-1:0] size);
    logic [WORD_BYTES-1:0] m;
    for (int unsigned i = 0; i < WORD_BYTES; i++) m[i] = (i < 32'(size));
    return m;
  endfunction
endpackage

// File: rtl/amo_order.sv
// Maps a value to memory lanes (or back); the mapping is its own inverse.
module amo_order #(
  parameter int unsigned N_BYTES = 8
) (
  input  logic [8*N_BYTES-1:0] src_i,
  input  logic [3:0]           size_i,
  input  logic                 big_i,
  output logic [8*N_BYTES-1:0] dst_o
);
  always_comb begin
    int unsigned n;
    n = (32'(size_i) > N_BYTES) ? N_BYTES : 32'(size_i);
    dst_o = '0;
    for (int unsigned i = 0; i < N_BYTES; i++) begin
      if (i < n) dst_o[8*i +: 8] = big_i ? src_i[8*(n-1-i) +: 8] : src_i[8*i +: 8];
    end
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
(
  input  amo_op_e     op_i,
  input  logic [3:0]  size_i,
  input  logic [63:0] old_i,
  input  logic [63:0] cmp_i,
  input  logic [63:0] opnd_i,
  output logic [63:0] new_o,
  output logic        hit_o
);
  logic [WORD_BYTES-1:0] bmask;
  logic [63:0]           vmask;

  always_comb begin
    bmask = size_mask(size_i);
    for (int unsigned i = 0; i < WORD_BYTES; i++) vmask[8*i +: 8] = {8{bmask[i]}};
  end

  always_comb begin
    if (op_i == OP_ADD) begin
      new_o = old_i + opnd_i;
      hit_o = 1'b1;
    end else begin
      new_o = opnd_i;
      hit_o = ((old_i ^ cmp_i) & vmask) == '0;
    end
  end
endmodule

// File: rtl/amo_store.sv
module amo_store #(
  parameter int unsigned ADDR_W   = 6,
  parameter int unsigned RD_BYTES = 8,
  parameter int unsigned WR_BYTES = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [ADDR_W-1:0]     rd_addr_i,
  output logic [8*RD_BYTES-1:0] rd_data_o,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     wr_addr_i,
  input  logic [8*WR_BYTES-1:0] wr_data_i,
  input  logic [WR_BYTES-1:0]   wr_be_i
);
  localparam int unsigned MEM_BYTES = 1 << ADDR_W;

  logic [7:0] mem_q [MEM_BYTES];
  logic [7:0] mem_d [MEM_BYTES];

  always_comb begin
    for (int unsigned j = 0; j < RD_BYTES; j++)
      rd_data_o[8*j +: 8] = mem_q[rd_addr_i + ADDR_W'(j)];
  end

  always_comb begin
    mem_d = mem_q;
    if (wr_en_i) begin
      for (int unsigned j = 0; j < WR_BYTES; j++)
        if (wr_be_i[j]) mem_d[wr_addr_i + ADDR_W'(j)] = wr_data_i[8*j +: 8];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int unsigned k = 0; k < MEM_BYTES; k++) mem_q[k] <= '0;
    end else begin
      mem_q <= mem_d;
    end
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [3:0]        req_size_i,
  input  logic              req_big_i,
  input  logic [63:0]       req_cmp_i,
  input  logic [63:0]       req_data_i,
  input  logic [63:0]       req_data_hi_i,
  input  logic              req_rel_i,
  output logic              rsp_valid_o,
  output logic              rsp_ok_o,
  output logic              rsp_err_o,
  output logic [63:0]       rsp_old_o,
  output logic              rsp_rel_o
);
  localparam int unsigned N_WORDS = 2;
  localparam int unsigned WR_BYTES = N_WORDS * WORD_BYTES;
  localparam logic [ADDR_W-1:0] HALF_BIT = ADDR_W'(WORD_BYTES);

  amo_state_e        state_q;
  amo_op_e           op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [3:0]        size_q;
  logic              big_q, rel_q, hit_q;
  logic [63:0]       cmp_q, d0_q, d1_q, old_q, new_q;

  logic              size_ok, align_ok, op_ok, legal;
  logic              accept;
  logic [63:0]       rd_lanes, rd_val, alu_new;
  logic              alu_hit;
  logic [63:0]       wr_src [N_WORDS];
  logic [8*WR_BYTES-1:0] wr_lanes;
  logic [WR_BYTES-1:0]   wr_be;
  logic [ADDR_W-1:0]     wr_addr;
  logic                  wr_en;
  logic                  pair_q;

  // request screening
  assign size_ok  = req_size_i inside {4'd1, 4'd2, 4'd4, 4'd8};
  assign align_ok = (req_addr_i & ADDR_W'(req_size_i - 4'd1)) == '0;
  assign op_ok    = (amo_op_e'(req_op_i) != OP_BAD) &&
                    ((amo_op_e'(req_op_i) != OP_CAS16) || (req_size_i == 4'd8));
  assign legal    = size_ok && align_ok && op_ok;
  assign accept   = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_ADD;
      addr_q  <= '0;
      size_q  <= '0;
      big_q   <= 1'b0;
      rel_q   <= 1'b0;
      cmp_q   <= '0;
      d0_q    <= '0;
      d1_q    <= '0;
      old_q   <= '0;
      new_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            op_q    <= amo_op_e'(req_op_i);
            addr_q  <= req_addr_i;
            size_q  <= req_size_i;
            big_q   <= req_big_i;
            rel_q   <= req_rel_i;
            cmp_q   <= req_cmp_i;
            d0_q    <= req_data_i;
            d1_q    <= req_data_hi_i;
            state_q <= legal ? ST_READ : ST_ERR;
          end
        end
        ST_READ: begin
          old_q   <= rd_val;
          state_q <= ST_CALC;
        end
        ST_CALC: begin
          new_q   <= alu_new;
          hit_q   <= alu_hit;
          state_q <= ST_WRITE;
        end
        ST_WRITE: state_q <= ST_IDLE;
        ST_ERR:   state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // read side
  amo_order #(.N_BYTES(WORD_BYTES)) u_rd_order (
    .src_i  (rd_lanes),
    .size_i (size_q),
    .big_i  (big_q),
    .dst_o  (rd_val)
  );

  amo_alu u_alu (
    .op_i   (op_q),
    .size_i (size_q),
    .old_i  (old_q),
    .cmp_i  (cmp_q),
    .opnd_i (d0_q),
    .new_o  (alu_new),
    .hit_o  (alu_hit)
  );

  // write side: word 0 carries the result, word 1 only for the paired exchange
  assign pair_q    = (op_q == OP_CAS16);
  assign wr_src[0] = new_q;
  assign wr_src[1] = d1_q;

  for (genvar g = 0; g < N_WORDS; g++) begin : g_wr_word
    amo_order #(.N_BYTES(WORD_BYTES)) u_wr_order (
      .src_i  (wr_src[g]),
      .size_i ((g == 0) ? size_q : 4'(WORD_BYTES)),
      .big_i  (big_q),
      .dst_o  (wr_lanes[8*WORD_BYTES*g +: 8*WORD_BYTES])
    );
  end

  assign wr_be   = pair_q ? {WR_BYTES{1'b1}} : {{WORD_BYTES{1'b0}}, size_mask(size_q)};
  assign wr_addr = pair_q ? (addr_q & ~HALF_BIT) : addr_q;
  assign wr_en   = (state_q == ST_WRITE) && hit_q;

  amo_store #(
    .ADDR_W   (ADDR_W),
    .RD_BYTES (WORD_BYTES),
    .WR_BYTES (WR_BYTES)
  ) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (addr_q),
    .rd_data_o (rd_lanes),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_lanes),
    .wr_be_i   (wr_be)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = (state_q == ST_WRITE) || (state_q == ST_ERR);
  assign rsp_err_o   = (state_q == ST_ERR);
  assign rsp_ok_o    = (state_q == ST_WRITE) && hit_q;
  assign rsp_old_o   = (state_q == ST_WRITE) ? old_q : '0;
  assign rsp_rel_o   = rel_q;
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int unsigned ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_op_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [3:0]        req_size_i,
  input logic              req_big_i,
  input logic [63:0]       req_cmp_i,
  input logic [63:0]       req_data_i,
  input logic [63:0]       req_data_hi_i,
  input logic              req_rel_i,
  input logic              rsp_valid_o,
  input logic              rsp_ok_o,
  input logic              rsp_err_o,
  input logic [63:0]       rsp_old_o,
  input logic              rsp_rel_o
);
  logic       acc, ok_req;
  logic       tag_q;
  logic [1:0] op_q;

  assign acc    = req_valid_i && req_ready_o;
  assign ok_req = (req_size_i == 4'd1 || req_size_i == 4'd2 ||
                   req_size_i == 4'd4 || req_size_i == 4'd8) &&
                  ((32'(req_addr_i) % 32'(req_size_i)) == 0) &&
                  (req_op_i != 2'd3) && (req_op_i != 2'd2 || req_size_i == 4'd8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag_q <= 1'b0;
      op_q  <= 2'd0;
    end else if (acc) begin
      tag_q <= req_rel_i;
      op_q  <= req_op_i;
    end
  end

  assert_busy_no_ready_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);
  assert_refuse_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && !ok_req) |=> (rsp_valid_o && rsp_err_o && !rsp_ok_o && rsp_old_o == '0));
  assert_latency_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ok_req) |=> !rsp_valid_o ##1 !rsp_valid_o ##1 (rsp_valid_o && !rsp_err_o));
  assert_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc && ok_req) |=> !req_ready_o ##1 !req_ready_o ##1 !req_ready_o);
  assert_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  assert_add_ok_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o && op_q == 2'd0) |-> rsp_ok_o);
  assert_ok_needs_rsp_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_ok_o |-> (rsp_valid_o && !rsp_err_o));
  assert_tag_echo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (rsp_rel_o == tag_q));
endmodule

bind amo_unit amo_unit_chk #(.ADDR_W(ADDR_W)) u_amo_unit_chk (.*);

// File: tb/amo_unit_test.sv
module amo_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 6;
  localparam int MEM_BYTES = 1 << ADDR_W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0] req_size = '0;
  logic req_big = 1'b0, req_rel = 1'b0;
  logic [63:0] req_cmp = '0, req_data = '0, req_data_hi = '0;
  logic rsp_valid, rsp_ok, rsp_err, rsp_rel;
  logic [63:0] rsp_old;

  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [MEM_BYTES];

  always #(CLK_PERIOD/2) clk = ~clk;

  amo_unit #(.ADDR_W(ADDR_W)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_big_i(req_big), .req_cmp_i(req_cmp), .req_data_i(req_data),
    .req_data_hi_i(req_data_hi), .req_rel_i(req_rel),
    .rsp_valid_o(rsp_valid), .rsp_ok_o(rsp_ok), .rsp_err_o(rsp_err),
    .rsp_old_o(rsp_old), .rsp_rel_o(rsp_rel)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] mdl_read(int a, int sz, logic big);
    logic [63:0] v = '0;
    for (int i = 0; i < sz; i++) v[8*(big ? sz-1-i : i) +: 8] = mdl[(a+i) % MEM_BYTES];
    return v;
  endfunction

  task automatic mdl_write(int a, int sz, logic big, logic [63:0] v);
    for (int i = 0; i < sz; i++) mdl[(a+i) % MEM_BYTES] = v[8*(big ? sz-1-i : i) +: 8];
  endtask

  // One request through the handshake, compared cycle by cycle with the model.
  task automatic issue(input logic [1:0] op, input int a, input int sz, input logic big,
                       input logic [63:0] cmp, input logic [63:0] d0, input logic [63:0] d1,
                       input logic rel, input string req);
    logic legal, e_ok;
    logic [63:0] e_old, mask;
    int lat;
    legal = (sz == 1 || sz == 2 || sz == 4 || sz == 8) && op != 2'd3 && (op != 2'd2 || sz == 8);
    if (legal) legal = (a % sz) == 0;
    e_old = '0; e_ok = 1'b0;
    if (legal) begin
      e_old = mdl_read(a, sz, big);
      mask = (sz == 8) ? '1 : ((64'd1 << (8*sz)) - 1);
      if (op == 2'd0) begin
        e_ok = 1'b1;
        mdl_write(a, sz, big, e_old + d0);
      end else begin
        e_ok = ((e_old ^ cmp) & mask) == '0;
        if (e_ok && op == 2'd1) mdl_write(a, sz, big, d0);
        if (e_ok && op == 2'd2) begin
          mdl_write(a & ~8, 8, big, d0);
          mdl_write((a & ~8) + 8, 8, big, d1);
        end
      end
    end
    lat = legal ? 3 : 1;
    @(negedge clk);
    chk({"R2 ready when idle ", req}, 64'(req_ready), 64'd1);
    chk({"R3 no response when idle ", req}, 64'(rsp_valid), 64'd0);
    req_valid = 1'b1; req_op = op; req_addr = ADDR_W'(a); req_size = 4'(sz);
    req_big = big; req_cmp = cmp; req_data = d0; req_data_hi = d1; req_rel = rel;
    @(posedge clk);
    for (int k = 1; k <= lat; k++) begin
      @(negedge clk);
      if (k == 1 && lat > 1) begin
        // conflicting request held while busy: must never be taken
        req_op = 2'd0; req_addr = '0; req_size = 4'd8; req_data = 64'hFFFF;
      end
      if (k == lat) req_valid = 1'b0;
      chk({"R3 busy ", req}, 64'(req_ready), 64'd0);
      chk({"R3 response timing ", req}, 64'(rsp_valid), 64'(k == lat));
      if (k == lat) begin
        chk({"R1 error flag ", req}, 64'(rsp_err), 64'(!legal));
        chk({"R4 R5 R6 R7 old value ", req}, rsp_old, e_old);
        chk({"R4 R5 R6 write flag ", req}, 64'(rsp_ok), 64'(e_ok));
        chk({"R8 tag echo ", req}, 64'(rsp_rel), 64'(rel));
      end
    end
  endtask

  // Mismatching exchange: reads 8 bytes without writing.
  task automatic peek(input int a, input string req);
    logic [63:0] w = mdl_read(a, 8, 1'b0);
    issue(2'd1, a, 8, 1'b0, w ^ 64'h1, '0, '0, 1'b0, req);
  endtask

  task automatic peek_all(input string req);
    for (int a = 0; a < MEM_BYTES; a += 8) peek(a, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < MEM_BYTES; i++) mdl[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 ready after reset", 64'(req_ready), 64'd1);
    chk("R9 no response in reset", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    peek_all("R9 memory zero");

    // R4 fetch-and-add, little and big endian, carry truncated
    issue(2'd0, 4, 4, 1'b0, '0, 64'h1122_3344, '0, 1'b0, "R4 add le4");
    issue(2'd0, 4, 4, 1'b0, '0, 64'hF000_0001_EEDD_CCBD, '0, 1'b1, "R4 add le4 carry");
    issue(2'd0, 7, 1, 1'b0, '0, 64'h2, '0, 1'b0, "R4 add byte");
    issue(2'd0, 12, 2, 1'b1, '0, 64'h0A0B, '0, 1'b0, "R7 add be2");
    issue(2'd0, 12, 2, 1'b1, '0, 64'h00F5, '0, 1'b0, "R7 add be2 wrap");
    issue(2'd0, 16, 8, 1'b0, '0, 64'h0102_0304_0506_0708, '0, 1'b1, "R4 add le8");
    peek_all("R4 R7 memory after adds");

    // R5 exchange
    issue(2'd1, 16, 4, 1'b0, 64'h0506_0708, 64'hDEAD_BEEF, '0, 1'b0, "R5 cas hit le4");
    issue(2'd1, 16, 4, 1'b0, 64'h1234_5678, 64'h0BAD_0BAD, '0, 1'b1, "R5 cas miss");
    issue(2'd1, 24, 8, 1'b1, 64'h0, 64'h8877_6655_4433_2211, '0, 1'b0, "R7 cas hit be8");
    issue(2'd1, 26, 1, 1'b0, 64'hFFFF_FFFF_FFFF_FF66, 64'h5A, '0, 1'b0, "R5 cas low-byte compare");
    peek_all("R5 R7 memory after exchanges");

    // R6 paired exchange, upper-word address and big endian
    issue(2'd2, 40, 8, 1'b1, 64'h0, 64'hA1A2_A3A4_A5A6_A7A8, 64'hB1B2_B3B4_B5B6_B7B8,
          1'b1, "R6 pair hit upper addr");
    issue(2'd2, 32, 8, 1'b0, 64'h0, 64'h1, 64'h2, 1'b0, "R6 pair miss");
    issue(2'd2, 48, 8, 1'b0, 64'h0, 64'hC0C1_C2C3_C4C5_C6C7, 64'hD0D1_D2D3_D4D5_D6D7,
          1'b0, "R6 pair hit lower addr");
    peek_all("R6 R7 memory after pairs");

    // R1 refusals
    issue(2'd0, 0, 3, 1'b0, '0, 64'hFF, '0, 1'b1, "R1 size 3");
    issue(2'd1, 2, 4, 1'b0, '0, 64'hFF, '0, 1'b0, "R1 misaligned");
    issue(2'd3, 0, 8, 1'b0, '0, 64'hFF, '0, 1'b1, "R1 opcode 3");
    issue(2'd2, 8, 4, 1'b0, '0, 64'hFF, 64'hFF, 1'b0, "R1 pair size 4");
    issue(2'd0, 0, 0, 1'b0, '0, 64'hFF, '0, 1'b0, "R1 size 0");
    peek_all("R1 memory untouched");

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule